// File: doc/BRIEF.md
# I2C Register Target with Access Freeze

This block is an I2C-compatible target that lets a bus host read and write a bank of 8-bit registers through an internal register pointer. SCL and SDA are sampled by the fast system clock through synchronizers, so the block needs no second clock domain. It detects START, repeated START and STOP conditions. It matches a fixed 7-bit device address. The first byte of a write loads the pointer, and the bytes after it are stored at that pointer and at the addresses that follow. A read (repeated START, address with the read bit) returns bytes from the pointer onward. The register bank itself sits outside the block and is reached through a plain port: address, write data, write strobe, and read data that follows the address combinationally.

The block also drives a freeze output. An addressed transaction raises it as soon as the pointer falls inside a configurable window of event-queue and event-counter registers. It stays high across repeated STARTs and drops only at STOP. The neighbouring event logic holds its updates while freeze is high and applies the queued ones afterwards.

Top module: `i2c_regbank_target`

## Requirements
- R1: Only an address byte whose upper seven bits equal DEV_ADDR (default 0x34) is acknowledged. After a mismatch the target drives nothing and writes nothing until the next START or STOP.
- R2: A write transaction (START, address with bit 0 = 0, pointer byte, data byte, STOP) produces exactly one single-cycle write strobe, with the address equal to the pointer and the write data equal to the data byte.
- R3: The target pulls SDA low for the whole ninth clock after a matching address byte, after the pointer byte and after every write data byte.
- R4: In a write burst, the pointer advances by one after each data byte, so successive bytes land at successive addresses.
- R5: After a repeated START with address bit 0 = 1, the target shifts out the register at the pointer, most significant bit first.
- R6: In a read, a host ACK (SDA low on the ninth clock) advances the pointer and starts the next byte. A host NACK releases SDA, ends the data phase and leaves the pointer unchanged.
- R7: The target changes its SDA drive only while SCL is low. Otherwise SDA is released, and the output enable is high only for an ACK or a read bit of value 0.
- R8: In an addressed transaction, freeze rises once the pointer lies in [FRZ_LO, FRZ_HI] (default 0x10 to 0x1F). It stays high across a repeated START and falls at STOP.
- R9: Freeze stays low when the pointer is outside the window, and in a transaction whose address was not matched.
- R10: After reset, SDA is released, freeze is low, the write strobe is low and the register address is 0.
- R11: Transfers work with SCL high and low phases as short as 8 system clocks. At a 200 MHz clock this covers 1 MHz SCL with margin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the pad |
| sda_i | input | 1 | SDA line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr_o | output | PTR_W | Register bank address (current pointer) |
| reg_wdata_o | output | 8 | Register bank write data |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_rdata_i | input | 8 | Register bank read data for reg_addr_o |
| freeze_o | output | 1 | Holds event-queue and counter updates |

## Verification
A table of single-byte writes and reads exercises the address decode with the matching address, an address differing only in the read/write bit position, and a shifted address. It also covers data patterns with a set MSB, a set LSB and alternating bits, and the pointer at 0xFF, so that bit order, ACK placement and mismatch handling can each be told apart. Directed bursts of three bytes separate pointer increment on writes from increment on host ACK versus NACK in reads. Freeze is driven with the pointer inside and outside its window, across a repeated START and with a foreign address. A final pass at minimum SCL phase lengths shows that the synchronizer delay still leaves SDA valid before the rising edge.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_IGNORE
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ch_q, sda_ch_q;
  logic [STAGES-1:0] scl_ch_d, sda_ch_d;
  logic              scl_dly_q, sda_dly_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb begin
        scl_ch_d = scl_i;
        sda_ch_d = sda_i;
      end
    end else begin : g_many
      always_comb begin
        scl_ch_d = {scl_ch_q[STAGES-2:0], scl_i};
        sda_ch_d = {sda_ch_q[STAGES-2:0], sda_i};
      end
    end
  endgenerate

  // idle bus is high: reset the chain to ones so no false edge appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ch_q  <= '1;
      sda_ch_q  <= '1;
      scl_dly_q <= 1'b1;
      sda_dly_q <= 1'b1;
    end else begin
      scl_ch_q  <= scl_ch_d;
      sda_ch_q  <= sda_ch_d;
      scl_dly_q <= scl_ch_q[STAGES-1];
      sda_dly_q <= sda_ch_q[STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_ch_q[STAGES-1];
    sda_s     = sda_ch_q[STAGES-1];
    scl_rise  = scl_s & ~scl_dly_q;
    scl_fall  = ~scl_s & scl_dly_q;
    start_det = scl_s & scl_dly_q & sda_dly_q & ~sda_s;
    stop_det  = scl_s & scl_dly_q & ~sda_dly_q & sda_s;
  end

endmodule

// File: rtl/i2c_target_fsm.sv
`timescale 1ns/1ps
module i2c_target_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o,
  output logic              sda_oe_o,
  output logic              acc_live_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              hack_q, hack_d;
  logic              oe_q, oe_d;
  logic              we_q, we_d;
  logic              rx_state, rx_shift, rx_done;

  always_comb begin
    rx_state = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDATA);
    rx_shift = rx_state && scl_rise && (cnt_q != CNT_FULL);
    rx_done  = rx_state && scl_fall && (cnt_q == CNT_FULL);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    hack_d  = hack_q;
    oe_d    = oe_q;
    we_d    = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      cnt_d   = '0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      oe_d    = 1'b0;
      cnt_d   = '0;
    end else if (rx_shift) begin
      sh_d  = {sh_q[BYTE_W-2:0], sda_s};
      cnt_d = cnt_q + 1'b1;
    end else if (rx_done) begin
      cnt_d = '0;
      unique case (state_q)
        ST_ADDR: begin
          if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
            state_d = ST_ADDR_ACK;
            oe_d    = 1'b1;
            rw_d    = sh_q[0];
          end else begin
            state_d = ST_IGNORE;
          end
        end
        ST_PTR: begin
          ptr_d   = PTR_W'(sh_q);
          state_d = ST_PTR_ACK;
          oe_d    = 1'b1;
        end
        default: begin
          we_d    = 1'b1;
          state_d = ST_WDATA_ACK;
          oe_d    = 1'b1;
        end
      endcase
    end else begin
      unique case (state_q)
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              sh_d    = rdata_i;
              oe_d    = ~rdata_i[BYTE_W-1];
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_PTR;
            end
          end
        end
        ST_PTR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            ptr_d   = ptr_q + 1'b1;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              cnt_d   = '0;
              oe_d    = 1'b0;
              state_d = ST_RDATA_ACK;
            end else begin
              cnt_d = cnt_q + 1'b1;
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) begin
            hack_d = ~sda_s;
            if (!sda_s) ptr_d = ptr_q + 1'b1;
          end else if (scl_fall) begin
            if (hack_q) begin
              sh_d    = rdata_i;
              oe_d    = ~rdata_i[BYTE_W-1];
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      hack_q  <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      hack_q  <= hack_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
    end
  end

  always_comb begin
    ptr_o      = ptr_q;
    wdata_o    = sh_q;
    we_o       = we_q;
    sda_oe_o   = oe_q;
    acc_live_o = (state_q == ST_PTR_ACK) || (state_q == ST_WDATA) ||
                 (state_q == ST_WDATA_ACK) || (state_q == ST_RDATA) ||
                 (state_q == ST_RDATA_ACK);
  end

  // R7
  sda_chg_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s);

  // R2
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  // R1
  ignore_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> (!oe_q && !we_q));

  // R3
  bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

endmodule

// File: rtl/i2c_freeze_ctl.sv
`timescale 1ns/1ps
module i2c_freeze_ctl #(
  parameter int               PTR_W  = 8,
  parameter logic [PTR_W-1:0] FRZ_LO = 8'h10,
  parameter logic [PTR_W-1:0] FRZ_HI = 8'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_live,
  input  logic [PTR_W-1:0] ptr,
  input  logic             stop_det,
  output logic             freeze_o
);

  logic frz_q, frz_d;
  logic in_win;

  always_comb begin
    in_win = (ptr >= FRZ_LO) && (ptr <= FRZ_HI);
    frz_d  = frz_q;
    if (stop_det)                frz_d = 1'b0;
    else if (acc_live && in_win) frz_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_q <= 1'b0;
    else        frz_q <= frz_d;
  end

  assign freeze_o = frz_q;

  // R8
  freeze_stop_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !frz_q);

  // R9
  freeze_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_q) |-> $past(acc_live && in_win));

endmodule

// File: rtl/i2c_regbank_target.sv
`timescale 1ns/1ps
module i2c_regbank_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h34,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [PTR_W-1:0] FRZ_LO = 8'h10,
  parameter logic [PTR_W-1:0] FRZ_HI = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              freeze_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_n_s;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       acc_live;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .rdata_i    (reg_rdata_i),
    .ptr_o      (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .sda_oe_o   (sda_oe_o),
    .acc_live_o (acc_live)
  );

  i2c_freeze_ctl #(.PTR_W(PTR_W), .FRZ_LO(FRZ_LO), .FRZ_HI(FRZ_HI)) frz_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .acc_live (acc_live),
    .ptr      (reg_addr_o),
    .stop_det (stop_det),
    .freeze_o (freeze_o)
  );

endmodule

// File: tb/i2c_regbank_target_tb.sv
`timescale 1ns/1ps
module i2c_regbank_target_tb_top;

  logic       clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic       scl_h, sda_h;
  logic       sda_bus;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, freeze;

  assign sda_bus = sda_h & ~sda_oe;

  i2c_regbank_target dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_h),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_rdata_i (reg_rdata),
    .freeze_o    (freeze)
  );

  // bench-owned register bank
  logic [7:0] bank [256];
  logic       pre_en = 1'b0;
  logic [7:0] pre_addr = 8'h00, pre_data = 8'h00;
  int         we_cnt = 0;
  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) begin
    if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end else if (pre_en) begin
      bank[pre_addr] <= pre_data;
    end
  end

  int checks = 0, failures = 0;
  int q_cyc = 5, h_cyc = 10;
  bit done = 1'b0;

  // R7 monitor: output enable changes only while SCL is low
  logic oe_prev = 1'b0;
  int   r7_viol = 0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl_h) r7_viol = r7_viol + 1;
    oe_prev = sda_oe;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_addr = a; pre_data = d; pre_en = 1'b1;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic bus_start;
    sda_h = 1'b1; wait_cyc(q_cyc);
    scl_h = 1'b1; wait_cyc(h_cyc);
    sda_h = 1'b0; wait_cyc(h_cyc);
    scl_h = 1'b0; wait_cyc(q_cyc);
  endtask

  task automatic bus_stop;
    sda_h = 1'b0; wait_cyc(q_cyc);
    scl_h = 1'b1; wait_cyc(h_cyc);
    sda_h = 1'b1; wait_cyc(h_cyc);
  endtask

  task automatic put_bit(input logic b);
    sda_h = b;    wait_cyc(q_cyc);
    scl_h = 1'b1; wait_cyc(h_cyc);
    scl_h = 1'b0; wait_cyc(q_cyc);
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1'b1; wait_cyc(q_cyc);
    scl_h = 1'b1; wait_cyc(h_cyc / 2);
    b = sda_bus;  wait_cyc(h_cyc - h_cyc / 2);
    scl_h = 1'b0; wait_cyc(q_cyc);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~host_ack);
  endtask

  // {is_read, dev[6:0], ptr[7:0], data[7:0], 7'b0, expect_ack}
  localparam logic [31:0] VECS [8] = '{
    {1'b0, 7'h34, 8'h05, 8'hA5, 7'd0, 1'b1},
    {1'b0, 7'h34, 8'h06, 8'h3C, 7'd0, 1'b1},
    {1'b0, 7'h35, 8'h07, 8'h77, 7'd0, 1'b0},
    {1'b0, 7'h1A, 8'h08, 8'h11, 7'd0, 1'b0},
    {1'b1, 7'h34, 8'h40, 8'hC3, 7'd0, 1'b1},
    {1'b1, 7'h34, 8'h41, 8'h01, 7'd0, 1'b1},
    {1'b1, 7'h34, 8'hFF, 8'h80, 7'd0, 1'b1},
    {1'b0, 7'h34, 8'hFF, 8'h5E, 7'd0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic a1, a2, a3, b;
    logic [7:0] g0, g1, g2;
    int wc0;
    rst_n = 1'b0; scl_h = 1'b1; sda_h = 1'b1;
    for (int i = 0; i < 256; i++) bank[i] = 8'h00;
    wait_cyc(10);
    rst_n = 1'b1;
    wait_cyc(10);

    // R10 reset state
    check(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
    check(freeze == 1'b0, "R10 freeze", freeze, 0);
    check(reg_we == 1'b0, "R10 reg_we", reg_we, 0);
    check(reg_addr == 8'h00, "R10 reg_addr", reg_addr, 0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      logic [7:0]  p, d;
      logic [6:0]  dev;
      v = VECS[i]; dev = v[30:24]; p = v[23:16]; d = v[15:8];
      if (v[31]) begin
        preload(p, d);
        bus_start;
        send_byte({dev, 1'b0}, a1);
        send_byte(p, a2);
        bus_start;
        send_byte({dev, 1'b1}, a3);
        recv_byte(1'b0, g0);
        bus_stop;
        check((a1 & a2 & a3) == v[0], "R3 read acks", {a1, a2, a3}, 7);
        check(g0 == d, "R5 read data", g0, d);
      end else begin
        preload(p, ~d);
        wc0 = we_cnt;
        bus_start;
        send_byte({dev, 1'b0}, a1);
        send_byte(p, a2);
        send_byte(d, a3);
        bus_stop;
        if (v[0]) begin
          check(a1 & a2 & a3, "R3 write acks", {a1, a2, a3}, 7);
          check(bank[p] == d && we_cnt == wc0 + 1, "R2 write data", bank[p], d);
        end else begin
          check(!(a1 | a2 | a3), "R1 mismatch nack", {a1, a2, a3}, 0);
          check(bank[p] == ~d && we_cnt == wc0, "R1 no write", bank[p], ~d);
        end
      end
    end

    // R4 write burst
    wc0 = we_cnt;
    bus_start;
    send_byte({7'h34, 1'b0}, a1);
    send_byte(8'h20, a2);
    send_byte(8'hD1, a3);
    send_byte(8'hD2, a3);
    send_byte(8'hD3, a3);
    bus_stop;
    check(bank[8'h20] == 8'hD1, "R4 byte0", bank[8'h20], 8'hD1);
    check(bank[8'h21] == 8'hD2, "R4 byte1", bank[8'h21], 8'hD2);
    check(bank[8'h22] == 8'hD3, "R4 byte2", bank[8'h22], 8'hD3);
    check(we_cnt == wc0 + 3, "R4 strobe count", we_cnt - wc0, 3);

    // R6 read burst: ack, ack, nack
    preload(8'h30, 8'h11);
    preload(8'h31, 8'h22);
    preload(8'h32, 8'h33);
    bus_start;
    send_byte({7'h34, 1'b0}, a1);
    send_byte(8'h30, a2);
    bus_start;
    send_byte({7'h34, 1'b1}, a3);
    recv_byte(1'b1, g0);
    recv_byte(1'b1, g1);
    recv_byte(1'b0, g2);
    check(g0 == 8'h11, "R6 burst0", g0, 8'h11);
    check(g1 == 8'h22, "R6 burst1", g1, 8'h22);
    check(g2 == 8'h33, "R6 burst2", g2, 8'h33);
    get_bit(b);
    check(b == 1'b1 && sda_oe == 1'b0, "R6 released after nack", b, 1);
    bus_stop;
    // pointer stays at last byte after NACK
    bus_start;
    send_byte({7'h34, 1'b1}, a1);
    recv_byte(1'b0, g0);
    bus_stop;
    check(g0 == 8'h33, "R6 pointer held on nack", g0, 8'h33);

    // R8 freeze inside window, held over repeated START
    bus_start;
    send_byte({7'h34, 1'b0}, a1);
    send_byte(8'h12, a2);
    check(freeze == 1'b1, "R8 freeze raised", freeze, 1);
    bus_start;
    check(freeze == 1'b1, "R8 freeze held", freeze, 1);
    send_byte({7'h34, 1'b1}, a3);
    recv_byte(1'b0, g0);
    check(freeze == 1'b1, "R8 freeze during read", freeze, 1);
    bus_stop;
    check(freeze == 1'b0, "R8 freeze released", freeze, 0);

    // R9 outside window and foreign address
    bus_start;
    send_byte({7'h34, 1'b0}, a1);
    send_byte(8'h05, a2);
    check(freeze == 1'b0, "R9 outside window", freeze, 0);
    bus_stop;
    bus_start;
    send_byte({7'h22, 1'b0}, a1);
    send_byte(8'h12, a2);
    check(freeze == 1'b0, "R9 foreign address", freeze, 0);
    bus_stop;

    // R11 short SCL phases
    q_cyc = 4; h_cyc = 8;
    bus_start;
    send_byte({7'h34, 1'b0}, a1);
    send_byte(8'h60, a2);
    send_byte(8'h9A, a3);
    bus_stop;
    check(a1 & a2 & a3 && bank[8'h60] == 8'h9A, "R11 fast write", bank[8'h60], 8'h9A);
    bus_start;
    send_byte({7'h34, 1'b0}, a1);
    send_byte(8'h60, a2);
    bus_start;
    send_byte({7'h34, 1'b1}, a3);
    recv_byte(1'b0, g0);
    bus_stop;
    check(g0 == 8'h9A, "R11 fast read", g0, 8'h9A);

    check(r7_viol == 0, "R7 drive change with SCL high", r7_viol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule